// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches a recovered line data stream, one bit per receive clock, and drives a loss-of-signal status flag. It sets the flag when it sees a long unbroken run of zero bits. It clears the flag only after a full observation window of sampled bit periods contains no excessive-zero condition. What counts as excessive zeros depends on the selected line mode: a run of at least three zeros in the two short-threshold modes, and at least four in the long-threshold mode. The block also gives a one-cycle pulse for each excessive-zero run, which can feed an error counter.

Each port of a multi-port receiver has its own instance, clocked by that port's receive clock. A data-valid strobe marks the cycles that carry a bit. All counting happens only on those cycles, so the block can sit behind a gapped or clock-enabled datapath. Line decoding, clock recovery and analog signal detection are done elsewhere.

Top module: `los_detector`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `los_o` and `exz_o` are 0. Reset clears every counter and the excessive-zero history.
- R2: `los_o` rises on the clock edge that samples the `LOS_LEN`-th consecutive zero bit (`data_i`=0 with `valid_i`=1). A run of `LOS_LEN`-1 zeros followed by a 1 leaves it low.
- R3: The zero-run count saturates at `LOS_LEN`. However long a zero run lasts, `los_o` stays high and the run does not wrap around into a false clear or a second pulse.
- R4: For `mode_i` = 2'b00 or 2'b01, a zero run is excessive from its third zero, with threshold `THR_SHORT` = 3. `exz_o` is high for one cycle, the cycle after the edge that samples that zero.
- R5: For `mode_i` = 2'b10, a zero run is excessive from its fourth zero, with threshold `THR_LONG` = 4. The value 2'b11 behaves like 2'b00.
- R6: `exz_o` pulses at most once per zero run. It cannot pulse again until a sampled 1 ends the run.
- R7: While `los_o` is high, it falls on the edge that completes `WIN_LEN` consecutive sampled bit periods, none of which is part of an excessive zero run.
- R8: While `los_o` is high, every sampled zero bit that belongs to an excessive run restarts the clearing window from zero.
- R9: Cycles with `valid_i`=0 are ignored. `los_o` holds its value, `exz_o` stays 0, and neither the zero run nor the window advances.
- R10: A change on `mode_i` applies from the next sampled bit, which is tested against the new threshold. The change does not alter `los_o` by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Bit strobe; `data_i` is sampled when high |
| data_i | input | 1 | Recovered line bit, 1 = mark |
| mode_i | input | 2 | Line mode: 00 and 01 short threshold, 10 long threshold, 11 same as 00 |
| los_o | output | 1 | Loss-of-signal status |
| exz_o | output | 1 | One-cycle excessive-zero event pulse |

## Verification
The bench builds the block with `LOS_LEN` = 16 and `WIN_LEN` = 10 and keeps the thresholds at 3 and 4. With these values the bench can afford to test exact off-by-one boundaries on both ends: a 15-zero run against a 16-zero run, and a clear after 9 clean periods against one after 10. It can also run a zero run more than twice `LOS_LEN` long to reach saturation. Window restarts, gapped strobes and mode switches in the middle of a run are then placed at precise positions inside a window. A reset in the middle of an alarm is covered as well.

// File: rtl/los_pkg.sv
package los_pkg;

  typedef enum logic [1:0] {
    MODE_DS3  = 2'b00,
    MODE_STS1 = 2'b01,
    MODE_E3   = 2'b10,
    MODE_RSVD = 2'b11
  } line_mode_e;

endpackage

// File: rtl/los_zero_run.sv
module los_zero_run
  import los_pkg::*;
#(
  parameter int unsigned LOS_LEN   = 192,
  parameter int unsigned THR_SHORT = 3,
  parameter int unsigned THR_LONG  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       data_i,
  input  line_mode_e mode_i,
  output logic       excess_o,  // sampled zero is inside an excessive run
  output logic       first_o,   // first excessive bit of this run
  output logic       full_o     // run reaches LOS_LEN on this bit
);

  localparam int unsigned CW = $clog2(LOS_LEN + 2);
  localparam logic [CW-1:0] LOS_MAX = CW'(LOS_LEN);

  logic [CW-1:0] run_q, run_inc, thr;
  logic          fired_q;
  logic          zero_bit;

  always_comb begin
    unique case (mode_i)
      MODE_E3: thr = CW'(THR_LONG);
      default: thr = CW'(THR_SHORT);
    endcase
  end

  assign zero_bit = valid_i && !data_i;
  assign run_inc  = run_q + CW'(1);
  assign excess_o = zero_bit && (run_inc >= thr);
  assign first_o  = excess_o && !fired_q;
  assign full_o   = zero_bit && (run_inc >= LOS_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      fired_q <= 1'b0;
    end else if (valid_i) begin
      if (data_i) begin
        run_q   <= '0;
        fired_q <= 1'b0;
      end else begin
        if (run_q != LOS_MAX) run_q <= run_inc;
        if (first_o) fired_q <= 1'b1;
      end
    end
  end

  // R3
  run_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == LOS_MAX && zero_bit) |=> run_q == LOS_MAX);

  // R6
  one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_o && !data_i) |=> !first_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(run_q) && $stable(fired_q));

endmodule

// File: rtl/los_window.sv
module los_window #(
  parameter int unsigned WIN_LEN = 192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic set_i,     // run reached alarm length
  input  logic excess_i,  // excessive-zero bit this cycle
  output logic los_o
);

  localparam int unsigned WW = $clog2(WIN_LEN + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);

  logic [WW-1:0] win_q;
  logic          los_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      los_q <= 1'b0;
      win_q <= '0;
    end else if (valid_i) begin
      if (!los_q) begin
        win_q <= '0;
        if (set_i) los_q <= 1'b1;
      end else if (excess_i) begin
        win_q <= '0;
      end else if (win_q == WIN_LAST) begin
        win_q <= '0;
        los_q <= 1'b0;
      end else begin
        win_q <= win_q + WW'(1);
      end
    end
  end

  assign los_o = los_q;

  // R8
  win_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los_q && valid_i && excess_i) |=> (win_q == '0) && los_q);

  // R7
  clear_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(los_q) |-> $past(valid_i && !excess_i));

endmodule

// File: rtl/los_detector.sv
module los_detector
  import los_pkg::*;
#(
  parameter int unsigned LOS_LEN   = 192,
  parameter int unsigned WIN_LEN   = 192,
  parameter int unsigned THR_SHORT = 3,
  parameter int unsigned THR_LONG  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       data_i,
  input  logic [1:0] mode_i,
  output logic       los_o,
  output logic       exz_o
);

  logic excess, first, full;
  logic exz_q;

  los_zero_run #(
    .LOS_LEN  (LOS_LEN),
    .THR_SHORT(THR_SHORT),
    .THR_LONG (THR_LONG)
  ) u_run (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .mode_i  (line_mode_e'(mode_i)),
    .excess_o(excess),
    .first_o (first),
    .full_o  (full)
  );

  los_window #(
    .WIN_LEN(WIN_LEN)
  ) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .set_i   (full),
    .excess_i(excess),
    .los_o   (los_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exz_q <= 1'b0;
    else         exz_q <= first;
  end

  assign exz_o = exz_q;

  // R9
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(los_o) && !exz_o);

  // R2
  los_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(los_o) |-> $past(valid_i && !data_i));

  // R6
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exz_o |=> !exz_o);

endmodule

// File: tb/tb_los_detector.sv
module tb_los_detector;

  localparam int CLK_PERIOD = 10;
  localparam int LOS_LEN    = 16;
  localparam int WIN_LEN    = 10;

  typedef struct {
    logic  los;
    logic  exz;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid = 1'b0;
  logic       data = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       los_o, exz_o;

  int n_checks = 0;
  int n_fail   = 0;
  exp_t q[$];

  // reference state
  int m_run = 0;
  bit m_fired = 0;
  int m_win = 0;
  bit m_los = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  los_detector #(
    .LOS_LEN(LOS_LEN),
    .WIN_LEN(WIN_LEN)
  ) dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .valid_i(valid),
    .data_i (data),
    .mode_i (mode),
    .los_o  (los_o),
    .exz_o  (exz_o)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic send(input bit v, input bit d, input logic [1:0] md, input string tag);
    exp_t e;
    int thr;
    bit ex, first, full;
    @(negedge clk);
    valid = v; data = d; mode = md;
    thr = (md == 2'b10) ? 4 : 3;
    first = 0;
    if (v) begin
      ex = 0; full = 0;
      if (!d) begin
        ex = (m_run + 1) >= thr;
        full = (m_run + 1) >= LOS_LEN;
        first = ex && !m_fired;
        if (m_run < LOS_LEN) m_run++;
        if (first) m_fired = 1;
      end else begin
        m_run = 0; m_fired = 0;
      end
      if (!m_los) begin
        m_win = 0;
        if (full) m_los = 1;
      end else if (ex) m_win = 0;
      else if (m_win == WIN_LEN - 1) begin
        m_win = 0; m_los = 0;
      end else m_win++;
    end
    e.los = m_los; e.exz = first; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send_n(input int n, input bit d, input logic [1:0] md, input string tag);
    for (int i = 0; i < n; i++) send(1'b1, d, md, tag);
  endtask

  // monitor: compares one expected item per cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, los_o, e.los, "los_o");
        check(e.tag, exz_o, e.exz, "exz_o");
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", los_o, 1'b0, "los_o in reset");
    check("R1", exz_o, 1'b0, "exz_o in reset");
    rst_ni = 1'b1;
    send_n(3, 1, 2'b00, "R1");

    // R4 short threshold, mode 00
    send_n(2, 0, 2'b00, "R4");
    send(1, 1, 2'b00, "R4");
    send_n(3, 0, 2'b00, "R4");
    // R6 longer run gives no further pulse
    send_n(5, 0, 2'b00, "R6");
    send(1, 1, 2'b00, "R6");
    send_n(3, 0, 2'b00, "R6");
    send(1, 1, 2'b00, "R6");
    // R4 mode 01
    send_n(4, 0, 2'b01, "R4");
    send(1, 1, 2'b01, "R4");
    // R5 long threshold and reserved code
    send_n(3, 0, 2'b10, "R5");
    send(1, 1, 2'b10, "R5");
    send_n(5, 0, 2'b10, "R5");
    send(1, 1, 2'b10, "R5");
    send_n(3, 0, 2'b11, "R5");
    send(1, 1, 2'b11, "R5");

    // R10 mode switch mid-run: 3 zeros long mode, 4th under short mode
    send_n(3, 0, 2'b10, "R10");
    send(1, 0, 2'b00, "R10");
    send(1, 1, 2'b00, "R10");

    // R2 boundary
    send_n(LOS_LEN - 1, 0, 2'b00, "R2");
    send(1, 1, 2'b00, "R2");
    send_n(LOS_LEN, 0, 2'b00, "R2");
    // R3 saturation
    send_n(3 * LOS_LEN, 0, 2'b00, "R3");

    // R7 clear after WIN_LEN clean periods
    send_n(WIN_LEN - 1, 1, 2'b00, "R7");
    send(1, 1, 2'b00, "R7");
    send_n(3, 1, 2'b00, "R7");

    // R7 short zero runs are not excessive
    send_n(LOS_LEN, 0, 2'b00, "R7");
    for (int i = 0; i < 4; i++) begin
      send(1, 1, 2'b00, "R7");
      send_n(2, 0, 2'b00, "R7");
    end
    send_n(2, 1, 2'b00, "R7");

    // R8 window restart
    send_n(LOS_LEN, 0, 2'b00, "R8");
    send_n(6, 1, 2'b00, "R8");
    send_n(3, 0, 2'b00, "R8");
    send_n(WIN_LEN + 2, 1, 2'b00, "R8");

    // R9 idle cycles during alarm and during a run
    send_n(LOS_LEN, 0, 2'b00, "R9");
    send_n(5, 1, 2'b00, "R9");
    for (int i = 0; i < 20; i++) send(0, 0, 2'b00, "R9");
    send_n(WIN_LEN, 1, 2'b00, "R9");
    send_n(2, 0, 2'b00, "R9");
    for (int i = 0; i < 5; i++) send(0, 0, 2'b00, "R9");
    send(1, 0, 2'b00, "R9");
    send(1, 1, 2'b00, "R9");

    // R10 mode change during alarm does not clear
    send_n(LOS_LEN, 0, 2'b10, "R10");
    send(1, 1, 2'b00, "R10");
    send(1, 1, 2'b10, "R10");
    send(1, 1, 2'b01, "R10");

    // R1 reset mid-alarm
    wait (q.size() == 0);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1", los_o, 1'b0, "los_o after reset");
    check("R1", exz_o, 1'b0, "exz_o after reset");
    rst_ni = 1'b1;
    m_run = 0; m_fired = 0; m_win = 0; m_los = 0;
    send_n(2, 0, 2'b00, "R1");
    send(1, 0, 2'b00, "R1");
    send(1, 1, 2'b00, "R1");

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule